// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Qualifier

This block sits between an external asynchronous parallel bus and an on-chip command decoder. It watches three active-low strobes (chip select, write strobe and read/output strobe) together with the address and data buses. All of these arrive with no relation to the system clock. The block brings the strobes into the clock domain through two-flop synchronisers. It then rejects any strobe level that does not stay stable for a programmable number of clock cycles. After that it applies the write-inhibit rules and emits one clean write event for each genuine write cycle on the bus.

A write cycle opens when both enables (chip select and write strobe) are low while the output strobe is high. The address is taken at that moment, which is the fall of whichever enable went low last. The cycle closes when either enable goes high again, and the data is taken at that first rise. The address and data buses pass through a delay line whose length equals the synchroniser and filter latency. As a result, the values captured are the ones present on the pins at the strobe edge.

The output is a stream with a valid qualifier but no ready: each event is a single-cycle pulse. The consumer must accept it in that cycle, because the block offers no back-pressure. The event fields hold their value until the next event.

Top module: `wr_cycle_qual`

## Requirements
- R1: While reset is asserted, and after it until the first qualified write, `evt_valid` is 0.
- R2: A write cycle opens only while chip select and write strobe are both low and the output strobe is high. The captured address is the bus value present when the later of the two enables fell.
- R3: The cycle closes when either enable rises. The event then carries the opening address and the data-bus value present at that first rise. Changes to the data bus before the first rise are ignored, and so are changes after it.
- R4: If the output strobe is low at the moment both enables are low, no event is produced. If the output strobe falls while a cycle is open, the cycle is cancelled and no event is produced.
- R5: On any strobe, a level change that lasts fewer than `GLITCH_CYC` clock cycles (default 2) is ignored. A short low pulse starts no cycle, and a short high pulse ends no cycle.
- R6: If both enables are already low with the output strobe high when reset is released, the following rise produces no event.
- R7: After an event or a cancelled cycle, no new cycle opens until both enables have been high together. A strobe held low, or one enable toggling while the other stays low, yields at most one event.
- R8: `evt_valid` is high for exactly one clock cycle per qualified write. It follows the closing edge on the pins by `SYNC_STAGES + GLITCH_CYC + 1` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_rd_n | input | 1 | Output/read strobe, active low, asynchronous |
| bus_addr | input | ADDR_W | Address bus, asynchronous |
| bus_data | input | DATA_W | Data bus, asynchronous |
| evt_valid | output | 1 | One-cycle write event pulse |
| evt_addr | output | ADDR_W | Address of the latest event |
| evt_data | output | DATA_W | Data of the latest event |

## Verification
The bench drives write cycles in both enable orders: chip select falling first, then write strobe falling first. It also closes them with each enable rising first. The address bus changes while the first enable is low, and the data bus changes just after the first rise. This shows whether capture uses the later fall and the earlier rise rather than some other edge. The inhibit patterns are checked one by one:
- output strobe held low;
- output strobe falling mid-cycle;
- enables already low across reset;
- one enable toggling while the other stays low.

Each of these must yield no event, which separates the arming logic from the plain level decode. One-cycle pulses are placed on each strobe, including a high blip on the write strobe inside an open cycle. These show that the filter, and not the later cycle logic, removes them.

// File: rtl/wcq_pkg.sv
package wcq_pkg;
  typedef enum logic [1:0] {
    CYC_WAIT_RELEASE = 2'd0,
    CYC_ARMED        = 2'd1,
    CYC_OPEN         = 2'd2
  } cyc_state_t;

  localparam int unsigned STROBE_CNT = 3;
  localparam int unsigned IDX_CS     = 0;
  localparam int unsigned IDX_WR     = 1;
  localparam int unsigned IDX_RD     = 2;
endpackage

// File: rtl/wcq_strobe_filter.sv
module wcq_strobe_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level_sync,
  output logic level_clean
);
  localparam int unsigned CNT_W = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   clean_q;

  // Synchroniser chain, reset to the low (asserted) level so that
  // a released strobe must prove itself high after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
  end

  assign level_sync = sync_q[SYNC_STAGES-1];

  // Accept a new level only after it persisted GLITCH_CYC cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_q  <= 1'b0;
      hold_cnt <= '0;
    end else if (level_sync != clean_q) begin
      if (hold_cnt == CNT_LAST) begin
        clean_q  <= level_sync;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end else begin
      hold_cnt <= '0;
    end
  end

  assign level_clean = clean_q;
endmodule

// File: rtl/wcq_bus_delay.sv
module wcq_bus_delay #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= bus_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign bus_out = stage_q[DEPTH-1];
endmodule

// File: rtl/wcq_cycle_fsm.sv
module wcq_cycle_fsm
  import wcq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              wr_lvl,
  input  logic              rd_lvl,
  input  logic [ADDR_W-1:0] addr_al,
  input  logic [DATA_W-1:0] data_al,
  output logic              armed,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  cyc_state_t        state_q;
  logic [ADDR_W-1:0] addr_hold;
  logic              both_low;
  logic              both_high;

  assign both_low  = !cs_lvl && !wr_lvl;
  assign both_high = cs_lvl && wr_lvl;
  assign armed     = (state_q == CYC_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CYC_WAIT_RELEASE;
      addr_hold <= '0;
      evt_valid <= 1'b0;
      evt_addr  <= '0;
      evt_data  <= '0;
    end else begin
      evt_valid <= 1'b0;
      unique case (state_q)
        CYC_WAIT_RELEASE: begin
          if (both_high) state_q <= CYC_ARMED;
        end
        CYC_ARMED: begin
          if (both_low && rd_lvl) begin
            addr_hold <= addr_al;
            state_q   <= CYC_OPEN;
          end
        end
        CYC_OPEN: begin
          if (!rd_lvl) begin
            state_q <= CYC_WAIT_RELEASE;
          end else if (!both_low) begin
            evt_valid <= 1'b1;
            evt_addr  <= addr_hold;
            evt_data  <= data_al;
            state_q   <= CYC_WAIT_RELEASE;
          end
        end
        default: state_q <= CYC_WAIT_RELEASE;
      endcase
    end
  end
endmodule

// File: rtl/wr_cycle_qual.sv
module wr_cycle_qual
  import wcq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  localparam int unsigned ALIGN_DEPTH = SYNC_STAGES + GLITCH_CYC;
  localparam int unsigned BUS_W       = ADDR_W + DATA_W;

  logic [STROBE_CNT-1:0] pins;
  logic [STROBE_CNT-1:0] lvl_sync;
  logic [STROBE_CNT-1:0] lvl_clean;
  logic [BUS_W-1:0]      bus_aligned;
  logic                  cs_f, wr_f, rd_f, wr_s, armed;

  assign pins[IDX_CS] = bus_cs_n;
  assign pins[IDX_WR] = bus_wr_n;
  assign pins[IDX_RD] = bus_rd_n;

  for (genvar s = 0; s < STROBE_CNT; s++) begin : g_strobe
    wcq_strobe_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .GLITCH_CYC (GLITCH_CYC)
    ) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_async  (pins[s]),
      .level_sync (lvl_sync[s]),
      .level_clean(lvl_clean[s])
    );
  end

  assign cs_f = lvl_clean[IDX_CS];
  assign wr_f = lvl_clean[IDX_WR];
  assign rd_f = lvl_clean[IDX_RD];
  assign wr_s = lvl_sync[IDX_WR];

  wcq_bus_delay #(
    .WIDTH(BUS_W),
    .DEPTH(ALIGN_DEPTH)
  ) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in ({bus_addr, bus_data}),
    .bus_out(bus_aligned)
  );

  wcq_cycle_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_f),
    .wr_lvl   (wr_f),
    .rd_lvl   (rd_f),
    .addr_al  (bus_aligned[BUS_W-1:DATA_W]),
    .data_al  (bus_aligned[DATA_W-1:0]),
    .armed    (armed),
    .evt_valid(evt_valid),
    .evt_addr (evt_addr),
    .evt_data (evt_data)
  );
endmodule

// File: rtl/wcq_checker.sv
module wcq_checker #(
  parameter int unsigned GLITCH_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_f,
  input logic wr_f,
  input logic rd_f,
  input logic wr_s,
  input logic armed,
  input logic evt_valid
);
  // R8: event pulse lasts a single cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R4: an event is only issued while the output strobe was high
  a_r4_rd_high_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(rd_f));

  // R3: an event follows a rise of at least one enable
  a_r3_event_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(cs_f || wr_f));

  // R7: arming happens only after both enables were seen high
  a_r7_rearm_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(armed)) |-> $past(cs_f && wr_f));

  // R5: the filtered write strobe moves only after a stable synced level
  if (GLITCH_CYC >= 2) begin : g_glitch_chk
    a_r5_glitch_filtered: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_f) |-> ($past(wr_s) == wr_f && $past(wr_s, 2) == wr_f));
  end
endmodule

bind wr_cycle_qual wcq_checker #(.GLITCH_CYC(GLITCH_CYC)) u_wcq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_f     (cs_f),
  .wr_f     (wr_f),
  .rd_f     (rd_f),
  .wr_s     (wr_s),
  .armed    (armed),
  .evt_valid(evt_valid)
);

// File: tb/test_wr_cycle_qual.sv
module test_wr_cycle_qual;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b0, wr_n = 1'b0, rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          evt_valid;
  logic [AW-1:0] evt_addr;
  logic [DW-1:0] evt_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [AW+DW-1:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  wr_cycle_qual i_wr_cycle_qual (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
    .bus_addr(addr), .bus_data(data),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  task automatic expect_drained(input string tag);
    tick(12);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: pending events actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // Full write cycle: fall_cs_first picks which enable falls first,
  // rise_wr_first picks which rises first. Address and data are changed
  // around the edges so only the correct edges give the expected pair.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit fall_cs_first, input bit rise_wr_first, input string tag);
    push_exp(a, d, tag);
    addr = ~a;
    if (fall_cs_first) cs_n = 1'b0; else wr_n = 1'b0;
    tick(6);
    addr = a;
    if (fall_cs_first) wr_n = 1'b0; else cs_n = 1'b0;
    tick(6);
    addr = a ^ 16'h00FF;
    data = ~d;
    tick(6);
    data = d;
    if (rise_wr_first) wr_n = 1'b1; else cs_n = 1'b1;
    tick(1);
    data = d ^ 8'h5A;
    tick(6);
    cs_n = 1'b1;
    wr_n = 1'b1;
    expect_drained(tag);
  endtask

  // Scoreboard monitor
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_valid && evt_valid) begin
        checks++;
        errors++;
        $display("FAIL R8: evt_valid high two cycles actual=1 expected=0");
      end
      if (evt_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4/R6/R7 (no event expected): actual addr=%h data=%h expected=none",
                   evt_addr, evt_data);
        end else begin
          logic [AW+DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({evt_addr, evt_data} !== e) begin
            errors++;
            $display("FAIL %s: actual addr=%h data=%h expected addr=%h data=%h",
                     t, evt_addr, evt_data, e[AW+DW-1:DW], e[DW-1:0]);
          end
        end
      end
      prev_valid = evt_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: quiet during reset; R6: enables low with rd high across reset
    tick(5);
    checks++;
    if (evt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: evt_valid in reset actual=%b expected=0", evt_valid);
    end
    rst_n = 1'b1;
    tick(10);
    checks++;
    if (evt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: evt_valid after reset actual=%b expected=0", evt_valid);
    end
    wr_n = 1'b1;
    tick(3);
    cs_n = 1'b1;
    expect_drained("R6");

    // R2/R3: both fall orders and both rise orders
    do_write(16'h1234, 8'hA5, 1'b1, 1'b1, "R2 cs-first/wr-rise");
    do_write(16'hBEEF, 8'h3C, 1'b0, 1'b0, "R3 wr-first/cs-rise");
    do_write(16'h0F0F, 8'hC3, 1'b1, 1'b0, "R3 cs-first/cs-rise");

    // R4: rd held low while both enables low
    rd_n = 1'b0;
    tick(2);
    cs_n = 1'b0; wr_n = 1'b0;
    tick(8);
    cs_n = 1'b1; wr_n = 1'b1;
    tick(4);
    rd_n = 1'b1;
    expect_drained("R4 rd low");

    // R4: rd falls during an open cycle
    cs_n = 1'b0; wr_n = 1'b0;
    tick(8);
    rd_n = 1'b0;
    tick(8);
    wr_n = 1'b1; cs_n = 1'b1;
    tick(4);
    rd_n = 1'b1;
    expect_drained("R4 rd abort");

    // R5: one-cycle low pulse on cs while wr low
    wr_n = 1'b0;
    tick(8);
    cs_n = 1'b0;
    tick(1);
    cs_n = 1'b1;
    tick(8);
    wr_n = 1'b1;
    expect_drained("R5 cs short low");

    // R5: one-cycle high blip on wr inside an open cycle
    push_exp(16'h7777, 8'h99, "R5 wr short high");
    addr = 16'h7777;
    cs_n = 1'b0; wr_n = 1'b0;
    tick(8);
    data = 8'h11;
    wr_n = 1'b1;
    tick(1);
    wr_n = 1'b0;
    tick(8);
    data = 8'h99;
    wr_n = 1'b1;
    tick(1);
    data = 8'h00;
    tick(6);
    cs_n = 1'b1;
    expect_drained("R5 wr short high");

    // R7: cs held low, wr toggles twice -> only the first cycle counts
    push_exp(16'h4242, 8'h24, "R7 toggle");
    addr = 16'h4242;
    cs_n = 1'b0;
    wr_n = 1'b0;
    tick(8);
    data = 8'h24;
    wr_n = 1'b1;
    tick(8);
    addr = 16'h9999;
    data = 8'h66;
    wr_n = 1'b0;
    tick(8);
    wr_n = 1'b1;
    tick(8);
    cs_n = 1'b1;
    expect_drained("R7 toggle");

    // R7/R8: long low gives one event only, then recovery
    push_exp(16'hCAFE, 8'h81, "R8 long low");
    addr = 16'hCAFE;
    data = 8'h81;
    cs_n = 1'b0; wr_n = 1'b0;
    tick(200);
    cs_n = 1'b1; wr_n = 1'b1;
    expect_drained("R8 long low");
    do_write(16'h0001, 8'h7E, 1'b0, 1'b1, "R2 recovery");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule